// File: doc/BRIEF.md
# Montgomery Exponentiation Sequencer

This controller computes Z = X^E mod M without doing any arithmetic of its own. It issues a series of Montgomery products MM(a, b) = a·b·R⁻¹ mod M to an attached multiplier. Each request names two operand slots and a destination slot in a shared vector store. The multiplier answers each request with a done strobe. The sequencer first brings the base into the Montgomery domain and then walks the exponent from its highest set bit down to bit 0. For every bit it squares the accumulator, and for every set bit it follows the square with a multiply by the converted base. A final product by one takes the result back out of the domain.

Before the start pulse, the host fills four slots: the base X, R² mod M, R mod M and the constant 1. The block derives the scan length t from the exponent itself. It therefore handles short public exponents such as 3 or 65537, full-width private exponents, zero and all-ones alike. When the run completes, the result is in the accumulator slot.

Top module: `modexp_seq`

## Requirements
- R1: After a synchronous active-low reset, `busy`, `done` and `mm_start` are low.
- R2: The first request of every run has operand A = slot 0 (base X), operand B = slot 1 (R² mod M) and destination = slot 4 (converted base).
- R3: With t one more than the index of the top set bit of E, the run issues a square of the accumulator (slot 5) for each bit from t−1 down to 0. Each square of a set bit is immediately followed by a multiply of slot 5 by slot 4 into slot 5. Until the first square completes, slot 2 (R mod M) stands in for the accumulator.
- R4: The last request multiplies the accumulator by slot 3 (constant 1) into slot 5, so that slot 5 ends as X^E mod M.
- R5: E = 0 gives exactly two requests: the base conversion, then slot 2 times slot 3 into slot 5. The result is 1 mod M.
- R6: When `done` pulses, `op_count` equals 2 + t + popcount(E). For E = 0 it equals 2.
- R7: Each request is a one-cycle `mm_start` pulse. The selectors stay stable and no new request is issued until `mm_done` is seen.
- R8: `busy` is high from the cycle after an accepted start until the run completes. `done` is then a single-cycle pulse with `busy` low.
- R9: A `start` pulse while busy, and any change on `exponent` during a run, have no effect on the run in progress.
- R10: A synchronous `abort` returns the block to idle on the next cycle. No further request and no `done` pulse follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a run; sampled only when idle |
| abort | input | 1 | Synchronous return to idle |
| exponent | input | EXP_W | Exponent E, latched at start |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle completion pulse |
| mm_start | output | 1 | Multiplier request pulse |
| mm_opa_sel | output | 3 | Slot of operand A |
| mm_opb_sel | output | 3 | Slot of operand B |
| mm_dst_sel | output | 3 | Slot receiving the product |
| mm_done | input | 1 | Multiplier completion strobe |
| op_count | output | CNT_W | Requests issued in the current or last run |

## Verification
The hardest situation to reach is one where the order of operations is wrong but the request count is right. One example is a multiply issued before its square, or the stand-in for the accumulator used after the first write. Only the value of the final product exposes these faults. The bench therefore plays the multiplier itself. It performs real Montgomery products over an 8-bit modulus on its own slot array, and it seeds the accumulator slot with a wrong value. It then sweeps every 8-bit exponent with varying multiplier latency, so that every bit pattern and scan length reaches the final result. Separate runs inject a start pulse and a changed exponent mid-run, and an abort between requests.

// File: rtl/modexp_pkg.sv
// Shared types and slot codes for the exponentiation sequencer.
// Assumes the vector store decodes the 3-bit slot codes below.
package modexp_pkg;
    typedef enum logic [1:0] {
        OP_CONV_IN,
        OP_SQR,
        OP_MUL,
        OP_CONV_OUT
    } mm_op_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ISSUE,
        ST_WAIT
    } seq_st_e;

    localparam int SLOT_W = 3;
    localparam logic [SLOT_W-1:0] SLOT_BASE   = 3'd0;
    localparam logic [SLOT_W-1:0] SLOT_RSQ    = 3'd1;
    localparam logic [SLOT_W-1:0] SLOT_RMOD   = 3'd2;
    localparam logic [SLOT_W-1:0] SLOT_UNIT   = 3'd3;
    localparam logic [SLOT_W-1:0] SLOT_BASE_M = 3'd4;
    localparam logic [SLOT_W-1:0] SLOT_ACC    = 3'd5;
endpackage

// File: rtl/modexp_topbit.sv
// Leading-one finder: returns the index of the highest set bit of vec
// and whether any bit is set. Assumes W >= 2.
module modexp_topbit #(
    parameter int W  = 32,
    parameter int IW = $clog2(W)
) (
    input  logic [W-1:0]  vec,
    output logic [IW-1:0] idx,
    output logic          any
);
    // Scan upward so the last set bit seen is the highest one.
    always_comb begin
        idx = '0;
        any = 1'b0;
        for (int i = 0; i < W; i++) begin
            if (vec[i]) begin
                idx = IW'(i);
                any = 1'b1;
            end
        end
    end
endmodule

// File: rtl/modexp_opsel.sv
// Maps the current multiply step to its operand and destination slots.
// Assumes acc_fresh is set until the first square has written the accumulator.
module modexp_opsel
    import modexp_pkg::*;
(
    input  mm_op_e            op,
    input  logic              acc_fresh,
    output logic [SLOT_W-1:0] opa,
    output logic [SLOT_W-1:0] opb,
    output logic [SLOT_W-1:0] dst
);
    logic [SLOT_W-1:0] acc_src;

    // R mod M stands in for the accumulator until it is first written.
    always_comb acc_src = acc_fresh ? SLOT_RMOD : SLOT_ACC;

    // Slot decode per step.
    always_comb begin
        unique case (op)
            OP_CONV_IN: begin opa = SLOT_BASE; opb = SLOT_RSQ;    dst = SLOT_BASE_M; end
            OP_SQR:     begin opa = acc_src;   opb = acc_src;     dst = SLOT_ACC;    end
            OP_MUL:     begin opa = SLOT_ACC;  opb = SLOT_BASE_M; dst = SLOT_ACC;    end
            default:    begin opa = acc_src;   opb = SLOT_UNIT;   dst = SLOT_ACC;    end
        endcase
    end
endmodule

// File: rtl/modexp_seq.sv
// Left-to-right square-and-multiply sequencer in the Montgomery domain.
// Issues MM requests (start pulse, slot selectors held, wait for done).
// Assumes the host has filled base, R^2 mod M, R mod M and 1 before start,
// and that the multiplier raises mm_done only for an outstanding request.
module modexp_seq
    import modexp_pkg::*;
#(
    parameter int EXP_W = 32,
    localparam int IDX_W = $clog2(EXP_W),
    localparam int CNT_W = $clog2(2 * EXP_W + 3)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              abort,
    input  logic [EXP_W-1:0]  exponent,
    output logic              busy,
    output logic              done,
    output logic              mm_start,
    output logic [SLOT_W-1:0] mm_opa_sel,
    output logic [SLOT_W-1:0] mm_opb_sel,
    output logic [SLOT_W-1:0] mm_dst_sel,
    input  logic              mm_done,
    output logic [CNT_W-1:0]  op_count
);
    seq_st_e           st_q;
    mm_op_e            op_q;
    logic [EXP_W-1:0]  exp_q;
    logic [IDX_W-1:0]  bit_idx_q;
    logic              nz_q;
    logic              acc_fresh_q;
    logic              done_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [IDX_W-1:0]  top_idx;
    logic              top_any;
    logic              cur_bit;
    logic              last_bit;

    modexp_topbit #(.W(EXP_W), .IW(IDX_W)) topbit_i (
        .vec (exponent),
        .idx (top_idx),
        .any (top_any)
    );

    modexp_opsel opsel_i (
        .op        (op_q),
        .acc_fresh (acc_fresh_q),
        .opa       (mm_opa_sel),
        .opb       (mm_opb_sel),
        .dst       (mm_dst_sel)
    );

    // Exponent bit under scan and end-of-scan flag.
    always_comb begin
        cur_bit  = exp_q[bit_idx_q];
        last_bit = (bit_idx_q == '0);
    end

    // Main sequencing state: latch at start, step on each multiplier done.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q        <= ST_IDLE;
            op_q        <= OP_CONV_IN;
            exp_q       <= '0;
            bit_idx_q   <= '0;
            nz_q        <= 1'b0;
            acc_fresh_q <= 1'b1;
            done_q      <= 1'b0;
            cnt_q       <= '0;
        end else begin
            done_q <= 1'b0;
            if (abort) begin
                st_q <= ST_IDLE;
            end else begin
                unique case (st_q)
                    ST_IDLE: if (start) begin
                        exp_q       <= exponent;
                        bit_idx_q   <= top_idx;
                        nz_q        <= top_any;
                        acc_fresh_q <= 1'b1;
                        op_q        <= OP_CONV_IN;
                        cnt_q       <= '0;
                        st_q        <= ST_ISSUE;
                    end
                    ST_ISSUE: begin
                        cnt_q <= cnt_q + 1'b1;
                        st_q  <= ST_WAIT;
                    end
                    ST_WAIT: if (mm_done) begin
                        st_q <= ST_ISSUE;
                        unique case (op_q)
                            OP_CONV_IN: op_q <= nz_q ? OP_SQR : OP_CONV_OUT;
                            OP_SQR: begin
                                acc_fresh_q <= 1'b0;
                                if (cur_bit) begin
                                    op_q <= OP_MUL;
                                end else if (last_bit) begin
                                    op_q <= OP_CONV_OUT;
                                end else begin
                                    bit_idx_q <= bit_idx_q - 1'b1;
                                    op_q      <= OP_SQR;
                                end
                            end
                            OP_MUL: begin
                                if (last_bit) begin
                                    op_q <= OP_CONV_OUT;
                                end else begin
                                    bit_idx_q <= bit_idx_q - 1'b1;
                                    op_q      <= OP_SQR;
                                end
                            end
                            default: begin
                                st_q   <= ST_IDLE;
                                done_q <= 1'b1;
                            end
                        endcase
                    end
                    default: st_q <= ST_IDLE;
                endcase
            end
        end
    end

    // Status and request outputs.
    always_comb begin
        busy     = (st_q != ST_IDLE);
        mm_start = (st_q == ST_ISSUE);
        done     = done_q;
        op_count = cnt_q;
    end

    // R7: a request lasts one cycle.
    a_r7_req_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        mm_start |=> !mm_start);
    // R7: selectors hold while a request is outstanding.
    a_r7_sel_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_WAIT && !mm_done && !abort) |=>
        ($stable(mm_opa_sel) && $stable(mm_opb_sel) && $stable(mm_dst_sel) && !mm_start));
    // R2: the first request of a run converts the base.
    a_r2_first_conv: assert property (@(posedge clk) disable iff (!rst_n)
        (mm_start && op_count == '0) |->
        (mm_opa_sel == SLOT_BASE && mm_opb_sel == SLOT_RSQ && mm_dst_sel == SLOT_BASE_M));
    // R8: done is a single pulse and comes with busy low.
    a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    a_r8_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
    // R9: start while busy leaves the latched exponent alone.
    a_r9_ignore_start: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start && !abort) |=> $stable(exp_q));
    // R10: abort leads to idle with no completion pulse.
    a_r10_abort_idle: assert property (@(posedge clk) disable iff (!rst_n)
        abort |=> (!busy && !done));
    // R6: a completed run has at least the two conversions.
    a_r6_min_count: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (op_count >= CNT_W'(2)));
endmodule

// File: tb/modexp_seq_tb.sv
// Bench: plays the Montgomery multiplier over an 8-bit modulus and sweeps
// every 8-bit exponent, checking final value, request count and handshake.
module modexp_seq_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int EW = 8;
    localparam int CW = $clog2(2 * EW + 3);
    localparam int MODV = 239;
    localparam int RV = 256;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          abort = 1'b0;
    logic [EW-1:0] exponent = '0;
    logic          busy, done, mm_start, mm_done;
    logic [2:0]    opa, opb, dst;
    logic [CW-1:0] op_count;

    int total = 0;
    int bad = 0;
    int slots [6];
    int rinv;

    always #(CLK_PERIOD / 2) clk = ~clk;

    modexp_seq #(.EXP_W(EW)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .abort(abort),
        .exponent(exponent), .busy(busy), .done(done), .mm_start(mm_start),
        .mm_opa_sel(opa), .mm_opb_sel(opb), .mm_dst_sel(dst),
        .mm_done(mm_done), .op_count(op_count)
    );

    initial mm_done = 1'b0;

    task automatic chk(input bit ok, input string req, input int act, input int exp_v);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp_v);
        end
    endtask

    function automatic int mm(input int a, input int b);
        return ((a * b) % MODV) * rinv % MODV;
    endfunction

    function automatic int modpow(input int x, input int e);
        int r = 1 % MODV;
        for (int i = 0; i < e; i++) r = (r * x) % MODV;
        return r;
    endfunction

    // One run; mode 0 plain, 1 start/exponent disturbance mid-run, 2 abort after two requests.
    task automatic run_exp(input int e, input int x, input int mode);
        int nops = 0;
        int t = 0;
        int pc = 0;
        bit fin = 0;
        slots[0] = x; slots[1] = (RV * RV) % MODV; slots[2] = RV % MODV;
        slots[3] = 1; slots[4] = 0; slots[5] = 77;
        for (int i = 0; i < EW; i++) if (e[i]) begin t = i + 1; pc++; end
        exponent = EW'(e);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b1, "R8 busy after start", int'(busy), 1);
        while (!fin) begin
            if (mm_start) begin
                int a = int'(opa);
                int b = int'(opb);
                int d = int'(dst);
                int lat = (nops + e) % 3;
                if (nops == 0)
                    chk(a == 0 && b == 1 && d == 4, "R2 first request slots", a * 100 + b * 10 + d, 14);
                nops++;
                for (int k = 0; k <= lat; k++) begin
                    @(negedge clk);
                    chk(!mm_start && busy, "R7 no request while waiting", int'(mm_start), 0);
                    if (mode == 1 && nops == 1 && k == 0) begin
                        start = 1'b1;
                        exponent = ~EW'(e);
                    end else begin
                        start = 1'b0;
                    end
                end
                if (mode == 2 && nops == 2) begin
                    abort = 1'b1;
                    @(negedge clk);
                    abort = 1'b0;
                    chk(!busy, "R10 idle after abort", int'(busy), 0);
                    for (int k = 0; k < 6; k++) begin
                        @(negedge clk);
                        chk(!mm_start && !done, "R10 quiet after abort", int'(mm_start) + int'(done), 0);
                    end
                    return;
                end
                if (a < 0 || a > 5 || b < 0 || b > 5 || d < 0 || d > 5) begin
                    chk(0, "R3 slot in range", d, 5);
                end else begin
                    slots[d] = mm(slots[a], slots[b]);
                end
                mm_done = 1'b1;
                @(negedge clk);
                mm_done = 1'b0;
            end else if (done) begin
                fin = 1;
                chk(!busy, "R8 busy low with done", int'(busy), 0);
                chk(int'(op_count) == 2 + t + pc, (e == 0) ? "R5 count for zero" : "R6 request count",
                    int'(op_count), 2 + t + pc);
                chk(slots[5] == modpow(x, e), (e == 0) ? "R5 zero exponent result" : "R3 R4 result",
                    slots[5], modpow(x, e));
                @(negedge clk);
                chk(!done, "R8 done single pulse", int'(done), 0);
            end else begin
                chk(0, "R7 expected request or done", int'(busy), 1);
                return;
            end
        end
    endtask

    initial begin
        for (int r = 1; r < MODV; r++) if ((RV * r) % MODV == 1) rinv = r;
        repeat (3) @(negedge clk);
        chk(!busy && !done && !mm_start, "R1 reset state", int'(busy) + int'(done) + int'(mm_start), 0);
        rst_n = 1'b1;
        @(negedge clk);
        for (int e = 0; e < 256; e++) run_exp(e, (e * 37 + 5) % MODV, 0);
        run_exp(255, 0, 0);
        run_exp(3, MODV - 1, 0);
        run_exp(8'hB5, 17, 1);
        run_exp(8'hFF, 9, 2);
        run_exp(1, 123, 0);
        run_exp(0, 200, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule